// File: doc/BRIEF.md
# Vector Length Control Unit

This block owns the two architectural length registers of a vector pipeline: the current vector length (VL) and the maximum vector length (MVL). A decoded length descriptor arrives with a one-cycle valid strobe. It carries a 2-bit mode, a 6-bit immediate, a 3-bit compact source index and a 5-bit destination index. The unit computes the new lengths, registers them on the next clock edge, and in that same cycle raises a one-cycle request to write the new VL into a scalar register.

The immediate holds a length minus one, so it covers lengths 1 to 64. The modes behave as follows:
- Mode 0 sets VL from the immediate, clipped to MVL.
- Mode 1 sets VL from a scalar register in the compact window x8..x15, clipped to MVL.
- Mode 2 sets MVL and VL together from the immediate.
- Mode 3 is reserved. It is accepted only when every other field is zero, and in that case it changes nothing.

The unit never rounds a length down. Apart from clipping to MVL, VL is always exactly the requested value.

Top module: `vlen_ctrl`

## Requirements
- R1: After reset, VL and MVL both read 64, and the writeback enable and illegal flag are low.
- R2: Mode 0 (mode=2'b00) sets VL to min(imm+1, MVL) and leaves MVL unchanged; VL never exceeds MVL.
- R3: In mode 0 and mode 2, the new VL is written to register rd (wb_data = VL, zero-extended) only when rd is nonzero. When rd is 0, no write is requested.
- R4: The source register index is combinational: it equals 8 + src (the compact window x8..x15).
- R5: Mode 1 (2'b01) sets VL to min(source value, MVL), comparing all 32 bits of the source value, and leaves MVL unchanged.
- R6: Mode 1 always requests a writeback of the new VL to register 8 + rd[2:0].
- R7: Mode 2 (2'b10) sets both MVL and VL to imm+1.
- R8: Mode 3 (2'b11) with imm, src and rd all zero leaves VL and MVL unchanged, requests no writeback and does not raise the illegal flag.
- R9: Mode 3 with any nonzero field raises the illegal flag for exactly one cycle, requests no writeback, and leaves VL and MVL unchanged.
- R10: All results appear in the cycle after the clock edge that samples the valid strobe, and the writeback request lasts exactly that one cycle.
- R11: While valid is low, the descriptor fields have no effect. VL and MVL hold, and no writeback or illegal flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor strobe |
| desc_mode | input | 2 | Descriptor mode |
| desc_imm | input | 6 | Length minus one |
| desc_src | input | 3 | Compact source index |
| desc_rd | input | 5 | Destination register index |
| rs_idx | output | 5 | Scalar read index (8 + src) |
| rs_data | input | 32 | Scalar read data |
| vl | output | 7 | Current vector length |
| mvl | output | 7 | Maximum vector length |
| wb_en | output | 1 | Scalar writeback request |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback data |
| illegal | output | 1 | Illegal reserved encoding |

## Verification
The stimulus goes after MVL clipping in both ways it can happen. In one, an immediate larger than a shrunken MVL must yield MVL and not the raw request. In the other, a register source with high bits set must clip instead of wrapping to a small length, which a compare on truncated bits would produce. The x0 destination is exercised in the immediate modes, where a missing check would write the zero register. It is also exercised in mode 1, where a design that skipped the compact offset would send the write to x0 instead of x8. The reserved mode is sent both all-zero and with a single stray field bit; a design that is wrong here either flags the clean case or updates the lengths on the bad one. Idle cycles with garbage fields show whether the design leaks updates or holds the writeback strobe for more than one cycle.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
    typedef enum logic [1:0] {
        VM_IMM  = 2'b00,
        VM_REG  = 2'b01,
        VM_BOTH = 2'b10,
        VM_RSVD = 2'b11
    } vmode_e;

    localparam int unsigned COMPACT_BASE = 8;
endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
    import vlc_pkg::*;
#(
    parameter int unsigned IMM_W  = 6,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned CIDX_W = 3,
    localparam int unsigned LEN_W = IMM_W + 1
) (
    input  logic              valid,
    input  logic [1:0]        mode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [CIDX_W-1:0] src,
    input  logic [IDX_W-1:0]  rd,
    output logic [LEN_W-1:0]  imm_len,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              upd_vl,
    output logic              upd_mvl,
    output logic              use_reg,
    output logic              wb_req,
    output logic              bad_enc
);
    vmode_e     m;
    logic       any_field;

    always_comb begin
        m         = vmode_e'(mode);
        any_field = (|imm) | (|src) | (|rd);
        imm_len   = LEN_W'(imm) + LEN_W'(1);
        src_idx   = IDX_W'(COMPACT_BASE) + IDX_W'(src);
        dst_idx   = rd;
        upd_vl    = 1'b0;
        upd_mvl   = 1'b0;
        use_reg   = 1'b0;
        wb_req    = 1'b0;
        bad_enc   = 1'b0;
        if (valid) begin
            unique case (m)
                VM_IMM: begin
                    upd_vl = 1'b1;
                    wb_req = |rd;
                end
                VM_REG: begin
                    upd_vl  = 1'b1;
                    use_reg = 1'b1;
                    wb_req  = 1'b1;
                    dst_idx = IDX_W'(COMPACT_BASE) + IDX_W'(rd[CIDX_W-1:0]);
                end
                VM_BOTH: begin
                    upd_vl  = 1'b1;
                    upd_mvl = 1'b1;
                    wb_req  = |rd;
                end
                VM_RSVD: begin
                    bad_enc = any_field;
                end
            endcase
        end
    end
endmodule

// File: rtl/vlc_clip.sv
module vlc_clip #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned LEN_W = 7
) (
    input  logic [XLEN-1:0]  req,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] len
);
    always_comb begin
        if (req > XLEN'(limit)) len = limit;
        else                    len = req[LEN_W-1:0];
    end
endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
    import vlc_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned IMM_W  = 6,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned CIDX_W = 3,
    localparam int unsigned LEN_W   = IMM_W + 1,
    localparam int unsigned MAX_LEN = 1 << IMM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [1:0]        desc_mode,
    input  logic [IMM_W-1:0]  desc_imm,
    input  logic [CIDX_W-1:0] desc_src,
    input  logic [IDX_W-1:0]  desc_rd,
    output logic [IDX_W-1:0]  rs_idx,
    input  logic [XLEN-1:0]   rs_data,
    output logic [LEN_W-1:0]  vl,
    output logic [LEN_W-1:0]  mvl,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              illegal
);
    typedef struct packed {
        logic [LEN_W-1:0] vl;
        logic [LEN_W-1:0] mvl;
        logic             wb_en;
        logic [IDX_W-1:0] wb_idx;
        logic [XLEN-1:0]  wb_data;
        logic             ill;
    } state_t;

    state_t state_d, state_q;

    logic [LEN_W-1:0] imm_len;
    logic [IDX_W-1:0] dst_idx;
    logic             upd_vl, upd_mvl, use_reg, wb_req, bad_enc;
    logic [XLEN-1:0]  req_len;
    logic [LEN_W-1:0] clip_len;

    vlc_decode #(
        .IMM_W (IMM_W),
        .IDX_W (IDX_W),
        .CIDX_W(CIDX_W)
    ) u_dec (
        .valid  (desc_valid),
        .mode   (desc_mode),
        .imm    (desc_imm),
        .src    (desc_src),
        .rd     (desc_rd),
        .imm_len(imm_len),
        .src_idx(rs_idx),
        .dst_idx(dst_idx),
        .upd_vl (upd_vl),
        .upd_mvl(upd_mvl),
        .use_reg(use_reg),
        .wb_req (wb_req),
        .bad_enc(bad_enc)
    );

    assign req_len = use_reg ? rs_data : XLEN'(imm_len);

    vlc_clip #(
        .XLEN (XLEN),
        .LEN_W(LEN_W)
    ) u_clip (
        .req  (req_len),
        .limit(state_q.mvl),
        .len  (clip_len)
    );

    always_comb begin
        state_d         = state_q;
        state_d.wb_en   = wb_req;
        state_d.ill     = bad_enc;
        state_d.wb_idx  = dst_idx;
        if (upd_mvl) begin
            state_d.mvl = imm_len;
            state_d.vl  = imm_len;
        end else if (upd_vl) begin
            state_d.vl  = clip_len;
        end
        state_d.wb_data = XLEN'(state_d.vl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.vl      <= LEN_W'(MAX_LEN);
            state_q.mvl     <= LEN_W'(MAX_LEN);
            state_q.wb_en   <= 1'b0;
            state_q.wb_idx  <= '0;
            state_q.wb_data <= '0;
            state_q.ill     <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign vl      = state_q.vl;
    assign mvl     = state_q.mvl;
    assign wb_en   = state_q.wb_en;
    assign wb_idx  = state_q.wb_idx;
    assign wb_data = state_q.wb_data;
    assign illegal = state_q.ill;
endmodule

// File: rtl/vlc_checker.sv
module vlc_checker #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned LEN_W = 7,
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             desc_valid,
    input logic [1:0]       desc_mode,
    input logic [LEN_W-1:0] vl,
    input logic [LEN_W-1:0] mvl,
    input logic             wb_en,
    input logic [IDX_W-1:0] wb_idx,
    input logic [XLEN-1:0]  wb_data,
    input logic             illegal
);
    p_vl_le_mvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vl <= mvl);

    p_wb_not_x0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_idx != '0);

    p_wb_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_data == XLEN'(vl));

    p_reg_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_mode == 2'b01) |=> (wb_en && wb_idx[IDX_W-1:3] == 2'b01));

    p_both_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_mode == 2'b10) |=> vl == mvl);

    p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_en && $stable(vl) && $stable(mvl)));

    p_idle_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_valid |=> (!wb_en && !illegal));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_valid |=> ($stable(vl) && $stable(mvl)));
endmodule

bind vlen_ctrl vlc_checker #(
    .XLEN (XLEN),
    .LEN_W(LEN_W),
    .IDX_W(IDX_W)
) u_vlc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_valid(desc_valid),
    .desc_mode (desc_mode),
    .vl        (vl),
    .mvl       (mvl),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data),
    .illegal   (illegal)
);

// File: tb/tb_vlen_ctrl.sv
module tb_vlen_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic [1:0]  desc_mode = '0;
    logic [5:0]  desc_imm = '0;
    logic [2:0]  desc_src = '0;
    logic [4:0]  desc_rd = '0;
    logic [4:0]  rs_idx;
    logic [31:0] rs_data = '0;
    logic [6:0]  vl, mvl;
    logic        wb_en, illegal;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlen_ctrl dut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_mode(desc_mode),
        .desc_imm(desc_imm), .desc_src(desc_src), .desc_rd(desc_rd),
        .rs_idx(rs_idx), .rs_data(rs_data), .vl(vl), .mvl(mvl),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [5:0]  imm;
        logic [2:0]  src;
        logic [4:0]  rd;
        logic [31:0] rsd;
        logic [6:0]  evl;
        logic [6:0]  emvl;
        logic        ewb;
        logic [4:0]  eidx;
        logic        eill;
    } vec_t;

    // Starting state VL=64, MVL=64; each row depends on the previous one.
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 6'd9,  3'd0, 5'd5,  32'd0,          7'd10, 7'd64, 1'b1, 5'd5,  1'b0}, // R2 R3
        '{2'd0, 6'd63, 3'd0, 5'd0,  32'd0,          7'd64, 7'd64, 1'b0, 5'd0,  1'b0}, // R3 rd=x0
        '{2'd2, 6'd15, 3'd0, 5'd7,  32'd0,          7'd16, 7'd16, 1'b1, 5'd7,  1'b0}, // R7
        '{2'd0, 6'd39, 3'd0, 5'd3,  32'd0,          7'd16, 7'd16, 1'b1, 5'd3,  1'b0}, // R2 clip
        '{2'd0, 6'd3,  3'd0, 5'd1,  32'd0,          7'd4,  7'd16, 1'b1, 5'd1,  1'b0}, // R2
        '{2'd1, 6'd0,  3'd2, 5'd5,  32'd100,        7'd16, 7'd16, 1'b1, 5'd13, 1'b0}, // R5 clip R6
        '{2'd1, 6'd0,  3'd7, 5'd0,  32'd5,          7'd5,  7'd16, 1'b1, 5'd8,  1'b0}, // R6 rd=0 -> x8
        '{2'd1, 6'd0,  3'd0, 5'd2,  32'd0,          7'd0,  7'd16, 1'b1, 5'd10, 1'b0}, // R5 zero
        '{2'd3, 6'd0,  3'd0, 5'd0,  32'd0,          7'd0,  7'd16, 1'b0, 5'd0,  1'b0}, // R8
        '{2'd3, 6'd1,  3'd0, 5'd0,  32'd0,          7'd0,  7'd16, 1'b0, 5'd0,  1'b1}, // R9
        '{2'd2, 6'd0,  3'd0, 5'd0,  32'd0,          7'd1,  7'd1,  1'b0, 5'd0,  1'b0}, // R7 len 1
        '{2'd1, 6'd0,  3'd3, 5'd1,  32'd1,          7'd1,  7'd1,  1'b1, 5'd9,  1'b0}, // R5
        '{2'd2, 6'd63, 3'd0, 5'd31, 32'd0,          7'd64, 7'd64, 1'b1, 5'd31, 1'b0}, // R7 len 64
        '{2'd1, 6'd0,  3'd1, 5'd4,  32'd64,         7'd64, 7'd64, 1'b1, 5'd12, 1'b0}, // R5 exact
        '{2'd3, 6'd0,  3'd0, 5'd1,  32'd0,          7'd64, 7'd64, 1'b0, 5'd0,  1'b1}, // R9 rd bit
        '{2'd1, 6'd0,  3'd5, 5'd6,  32'h8000_0000,  7'd64, 7'd64, 1'b1, 5'd14, 1'b0}  // R5 high bits
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle_fields();
        desc_valid = 1'b0;
        desc_mode  = 2'd2;
        desc_imm   = 6'd5;
        desc_src   = 3'd6;
        desc_rd    = 5'd9;
        rs_data    = 32'd3;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 vl", 32'(vl), 32'd64);
        check("R1 mvl", 32'(mvl), 32'd64);
        check("R1 wb_en", 32'(wb_en), 32'd0);
        check("R1 illegal", 32'(illegal), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: garbage fields with valid low change nothing
        idle_fields();
        repeat (2) @(negedge clk);
        check("R11 vl", 32'(vl), 32'd64);
        check("R11 mvl", 32'(mvl), 32'd64);
        check("R11 wb_en", 32'(wb_en), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            desc_valid = 1'b1;
            desc_mode  = TBL[i].mode;
            desc_imm   = TBL[i].imm;
            desc_src   = TBL[i].src;
            desc_rd    = TBL[i].rd;
            rs_data    = TBL[i].rsd;
            #1;
            check("R4 rs_idx", 32'(rs_idx), 32'd8 + 32'(TBL[i].src));
            @(negedge clk);
            check("R10 vl", 32'(vl), 32'(TBL[i].evl));
            check("R10 mvl", 32'(mvl), 32'(TBL[i].emvl));
            check("R3 wb_en", 32'(wb_en), 32'(TBL[i].ewb));
            check("R9 illegal", 32'(illegal), 32'(TBL[i].eill));
            if (TBL[i].ewb) begin
                check("R6 wb_idx", 32'(wb_idx), 32'(TBL[i].eidx));
                check("R3 wb_data", wb_data, 32'(TBL[i].evl));
            end
        end

        // R10: writeback lasts one cycle
        idle_fields();
        @(negedge clk);
        check("R10 wb_en drop", 32'(wb_en), 32'd0);
        check("R11 vl hold", 32'(vl), 32'd64);

        // R9: illegal pulse is a single cycle
        desc_valid = 1'b1; desc_mode = 2'd3; desc_imm = 6'd0; desc_src = 3'd4; desc_rd = 5'd0;
        @(negedge clk);
        check("R9 illegal high", 32'(illegal), 32'd1);
        check("R9 mvl hold", 32'(mvl), 32'd64);
        idle_fields();
        @(negedge clk);
        check("R9 illegal low", 32'(illegal), 32'd0);

        // R2 after MVL shrink: clip immediate
        desc_valid = 1'b1; desc_mode = 2'd2; desc_imm = 6'd7; desc_rd = 5'd0;
        @(negedge clk);
        desc_mode = 2'd0; desc_imm = 6'd8; desc_rd = 5'd2;
        @(negedge clk);
        check("R2 clip vl", 32'(vl), 32'd8);
        check("R2 clip mvl", 32'(mvl), 32'd8);
        idle_fields();
        @(negedge clk);

        // R1: reset mid-run restores 64
        rst_n = 1'b0;
        #1;
        check("R1 re-reset vl", 32'(vl), 32'd64);
        check("R1 re-reset mvl", 32'(mvl), 32'd64);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule